// File: doc/BRIEF.md
# Cache-Block Management Instruction Checker

This block inspects one 32-bit instruction word per request and decides whether it is a cache-block clean, flush or invalidate operation. For a recognised operation it applies the per-privilege enable rules taken from the machine-level and supervisor-level environment-configuration bits. It may quietly downgrade an invalidate to a flush. It computes the block-aligned address from the rs1 value and the block-size exponent.

It then merges the translation result and the read and write permission results from an external checker into a single outcome. The outcome is success, illegal instruction, or a store-class fault with its exception cause. Read permission alone or write permission alone is enough for success. Load-class faults never appear at the output: every fault is reported with a store-class cause.

The pipeline front end presents a request with `req_valid_i`. The registered result appears on the following cycle with a one-cycle `res_valid_o` strobe. The result fields hold their values between requests.

Top module: `cbm_checker`

## Requirements
- R1: A word is recognised only when bits 6:0 equal 0001111, bits 14:12 equal 010, bits 11:7 equal 00000, and bits 31:20 hold 0, 1 or 2. Any other word gives kind 0 (not a management operation), cause 0 and op code 3.
- R2: The op code reports the operation as follows: bits 31:20 equal to 0 means invalidate (op 0), 1 means clean (op 1) and 2 means flush (op 2). Priority is only altered by R5.
- R3: The privilege encoding is 00 user, 01 supervisor, 11 machine, and 10 is treated as user. An operation's enable is always on in machine mode. In supervisor mode it equals the machine-level bit. In user mode it needs the machine-level bit, and also either `s_mode_present_i` low or the supervisor-level bit set.
- R4: Clean and flush use the clean/flush enable bits, and invalidate uses bit 0 of the invalidate config fields. A disabled recognised operation gives kind 2 (illegal) with cause 2, regardless of any fault input.
- R5: An enabled invalidate is reported as op 2 (flush) when bit 1 of the invalidate config fields, evaluated through the R3 rule, is off. Otherwise it stays op 0.
- R6: The result address is rs1 with its low e bits cleared, where e is the block-size exponent. Exponent values above 12 are treated as 12.
- R7: For an enabled operation, a translation failure gives kind 3 (fault) with cause 15 if it was a page fault, else cause 7. This holds whatever the read and write checks say.
- R8: For an enabled operation without a translation failure, success (kind 1, cause 0) results when the read check or the write check passes.
- R9: When both the read and the write check fail, the result is kind 3 with cause 15 if the write failure is a page fault, else cause 7.
- R10: `res_valid_o` is high for exactly the cycle after each cycle with `req_valid_i` high. Result fields update only on a request and otherwise hold. Synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | A request is present this cycle |
| instr_i | input | 32 | Instruction word |
| priv_i | input | 2 | Current privilege (00 U, 01 S, 11 M, 10 as U) |
| m_cf_en_i | input | 1 | Machine-level clean/flush enable |
| m_inv_cfg_i | input | 2 | Machine-level invalidate field: bit 0 enable, bit 1 true invalidate |
| s_cf_en_i | input | 1 | Supervisor-level clean/flush enable |
| s_inv_cfg_i | input | 2 | Supervisor-level invalidate field, same layout |
| s_mode_present_i | input | 1 | Supervisor mode is implemented |
| rs1_i | input | ADDR_W | Base register value |
| blk_exp_i | input | EXP_W | log2 of the block size in bytes |
| xlat_fail_i | input | 1 | Address translation failed |
| xlat_page_i | input | 1 | The translation failure is a page fault |
| rd_fail_i | input | 1 | Read permission check failed |
| wr_fail_i | input | 1 | Write permission check failed |
| wr_page_i | input | 1 | The write failure is a page fault |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_kind_o | output | 2 | 0 not a management op, 1 success, 2 illegal, 3 fault |
| res_op_o | output | 2 | Effective operation: 0 invalidate, 1 clean, 2 flush, 3 none |
| res_cause_o | output | 5 | Exception cause: 0, 2, 7 or 15 |
| res_addr_o | output | ADDR_W | Block-aligned address |

## Verification
Every result of this block is due exactly one rising edge after the request that produced it, because one register stage sits between the inputs and the outputs. The bench drives each request on a falling edge and computes the expected outcome from those inputs before the next rising edge. It then compares all five result fields at the following falling edge, half a cycle after the register has updated. Idle cycles with changed inputs are compared the same way, against held values and a low strobe.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam logic [6:0] OPC_MISC_MEM  = 7'b0001111;
    localparam logic [2:0] F3_BLOCK_OP   = 3'b010;
    localparam int         MAX_BLK_EXP   = 12;

    localparam logic [4:0] CAUSE_NONE    = 5'd0;
    localparam logic [4:0] CAUSE_ILLEGAL = 5'd2;
    localparam logic [4:0] CAUSE_ST_ACC  = 5'd7;
    localparam logic [4:0] CAUSE_ST_PAGE = 5'd15;

    typedef enum logic [1:0] {
        PRV_U   = 2'b00,
        PRV_S   = 2'b01,
        PRV_RSV = 2'b10,
        PRV_M   = 2'b11
    } prv_e;

    typedef enum logic [1:0] {
        OP_INVAL = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_NONE  = 2'd3
    } blk_op_e;

    typedef enum logic [1:0] {
        RK_NONE    = 2'd0,
        RK_DONE    = 2'd1,
        RK_ILLEGAL = 2'd2,
        RK_FAULT   = 2'd3
    } res_kind_e;

    typedef struct packed {
        logic    hit;
        blk_op_e op;
    } dec_t;

    typedef struct packed {
        logic fail;
        logic page;
    } chk_t;

    // Two-level enable: machine always on, supervisor follows the machine
    // bit, user needs both levels (supervisor level only when implemented).
    function automatic logic level_on(input logic [1:0] prv, input logic m_bit,
                                      input logic s_bit, input logic s_present);
        logic on;
        case (prv)
            PRV_M:   on = 1'b1;
            PRV_S:   on = m_bit;
            default: on = m_bit & (~s_present | s_bit);
        endcase
        return on;
    endfunction

    function automatic logic [4:0] store_cause(input logic page);
        return page ? CAUSE_ST_PAGE : CAUSE_ST_ACC;
    endfunction

endpackage

// File: rtl/cbm_decode.sv
module cbm_decode
    import cbm_pkg::*;
(
    input  logic [31:0] instr_i,
    output dec_t        dec_o
);
    logic [11:0] sel;
    logic        frame_ok;
    logic        unused_reg_field;

    assign sel              = instr_i[31:20];
    assign unused_reg_field = ^instr_i[19:15];
    assign frame_ok         = (instr_i[6:0] == OPC_MISC_MEM) &&
                              (instr_i[14:12] == F3_BLOCK_OP) &&
                              (instr_i[11:7] == 5'd0);

    always_comb begin
        dec_o.hit = 1'b0;
        dec_o.op  = OP_NONE;
        if (frame_ok) begin
            case (sel)
                12'd0: begin dec_o.hit = 1'b1; dec_o.op = OP_INVAL; end
                12'd1: begin dec_o.hit = 1'b1; dec_o.op = OP_CLEAN; end
                12'd2: begin dec_o.hit = 1'b1; dec_o.op = OP_FLUSH; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cbm_align.sv
module cbm_align
    import cbm_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int EXP_W  = 4
) (
    input  logic [ADDR_W-1:0] rs1_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_BLK_EXP);

    logic [EXP_W-1:0] exp_c;
    assign exp_c = (exp_i > EXP_CAP) ? EXP_CAP : exp_i;

    // Bit g survives when g is at or above the clamped exponent; bits at or
    // above the maximum exponent always survive.
    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
        if (g >= MAX_BLK_EXP) begin : g_keep
            assign addr_o[g] = rs1_i[g];
        end else begin : g_mask
            assign addr_o[g] = rs1_i[g] & (exp_c <= EXP_W'(g));
        end
    end
endmodule

// File: rtl/cbm_resolve.sv
module cbm_resolve
    import cbm_pkg::*;
(
    input  logic       hit_i,
    input  logic       en_i,
    input  chk_t       xlat_i,
    input  logic       rd_fail_i,
    input  chk_t       wr_i,
    output res_kind_e  kind_o,
    output logic [4:0] cause_o
);
    always_comb begin
        kind_o  = RK_NONE;
        cause_o = CAUSE_NONE;
        if (hit_i) begin
            if (!en_i) begin
                kind_o  = RK_ILLEGAL;
                cause_o = CAUSE_ILLEGAL;
            end else if (xlat_i.fail) begin
                kind_o  = RK_FAULT;
                cause_o = store_cause(xlat_i.page);
            end else if (rd_fail_i && wr_i.fail) begin
                kind_o  = RK_FAULT;
                cause_o = store_cause(wr_i.page);
            end else begin
                kind_o  = RK_DONE;
            end
        end
    end
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker
    import cbm_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [31:0]       instr_i,
    input  logic [1:0]        priv_i,
    input  logic              m_cf_en_i,
    input  logic [1:0]        m_inv_cfg_i,
    input  logic              s_cf_en_i,
    input  logic [1:0]        s_inv_cfg_i,
    input  logic              s_mode_present_i,
    input  logic [ADDR_W-1:0] rs1_i,
    input  logic [EXP_W-1:0]  blk_exp_i,
    input  logic              xlat_fail_i,
    input  logic              xlat_page_i,
    input  logic              rd_fail_i,
    input  logic              wr_fail_i,
    input  logic              wr_page_i,
    output logic              res_valid_o,
    output logic [1:0]        res_kind_o,
    output logic [1:0]        res_op_o,
    output logic [4:0]        res_cause_o,
    output logic [ADDR_W-1:0] res_addr_o
);
    dec_t              dec;
    logic [ADDR_W-1:0] blk_addr;
    logic              cf_on, inv_on, inv_true, op_en;
    blk_op_e           eff_op;
    res_kind_e         kind_d;
    logic [4:0]        cause_d;

    cbm_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    cbm_align #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) u_align (
        .rs1_i  (rs1_i),
        .exp_i  (blk_exp_i),
        .addr_o (blk_addr)
    );

    assign cf_on    = level_on(priv_i, m_cf_en_i,      s_cf_en_i,      s_mode_present_i);
    assign inv_on   = level_on(priv_i, m_inv_cfg_i[0], s_inv_cfg_i[0], s_mode_present_i);
    assign inv_true = level_on(priv_i, m_inv_cfg_i[1], s_inv_cfg_i[1], s_mode_present_i);

    assign op_en  = (dec.op == OP_INVAL) ? inv_on : cf_on;
    assign eff_op = (dec.op == OP_INVAL && !inv_true) ? OP_FLUSH : dec.op;

    cbm_resolve u_res (
        .hit_i     (dec.hit),
        .en_i      (op_en),
        .xlat_i    ('{fail: xlat_fail_i, page: xlat_page_i}),
        .rd_fail_i (rd_fail_i),
        .wr_i      ('{fail: wr_fail_i, page: wr_page_i}),
        .kind_o    (kind_d),
        .cause_o   (cause_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o <= 1'b0;
            res_kind_o  <= 2'd0;
            res_op_o    <= 2'd0;
            res_cause_o <= 5'd0;
            res_addr_o  <= '0;
        end else begin
            res_valid_o <= req_valid_i;
            if (req_valid_i) begin
                res_kind_o  <= kind_d;
                res_op_o    <= eff_op;
                res_cause_o <= cause_d;
                res_addr_o  <= blk_addr;
            end
        end
    end

    // R10
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(req_valid_i));

    // R3
    machine_never_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && $past(priv_i) == PRV_M) |-> res_kind_o != RK_ILLEGAL);

    // R4
    illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && res_kind_o == RK_ILLEGAL) |-> res_cause_o == CAUSE_ILLEGAL);

    // R9
    store_class_only_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && res_kind_o == RK_FAULT) |->
            (res_cause_o == CAUSE_ST_ACC || res_cause_o == CAUSE_ST_PAGE));

    // R1
    no_match_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && res_kind_o == RK_NONE) |->
            (res_cause_o == CAUSE_NONE && res_op_o == OP_NONE));

    // R6
    aligned_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && $past(blk_exp_i) != '0) |-> res_addr_o[0] == 1'b0);

    // R5
    no_inval_without_true_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && $past(priv_i) == PRV_S && !$past(m_inv_cfg_i[1])) |->
            res_op_o != OP_INVAL);
endmodule

// File: tb/test_cbm_checker.sv
module test_cbm_checker;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] instr;
    logic [1:0]  priv;
    logic        m_cf, s_cf, s_pres;
    logic [1:0]  m_inv, s_inv;
    logic [63:0] rs1;
    logic [3:0]  bexp;
    logic        xf, xp, rf, wf, wp;

    logic        o_valid;
    logic [1:0]  o_kind, o_op;
    logic [4:0]  o_cause;
    logic [63:0] o_addr;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic        e_valid = 1'b0;
    int          e_kind = 0, e_op = 0, e_cause = 0;
    logic [63:0] e_addr = '0;

    always #5 clk = ~clk;

    cbm_checker i_cbm_checker (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .instr_i(instr),
        .priv_i(priv), .m_cf_en_i(m_cf), .m_inv_cfg_i(m_inv), .s_cf_en_i(s_cf),
        .s_inv_cfg_i(s_inv), .s_mode_present_i(s_pres), .rs1_i(rs1),
        .blk_exp_i(bexp), .xlat_fail_i(xf), .xlat_page_i(xp), .rd_fail_i(rf),
        .wr_fail_i(wf), .wr_page_i(wp), .res_valid_o(o_valid),
        .res_kind_o(o_kind), .res_op_o(o_op), .res_cause_o(o_cause),
        .res_addr_o(o_addr)
    );

    function automatic logic [31:0] mk(input int f12, input int f3 = 2,
                                       input int rd = 0, input int opc = 15);
        return {12'(f12), 5'd7, 3'(f3), 5'(rd), 7'(opc)};
    endfunction

    function automatic bit allowed(input int p, input bit m, input bit s, input bit sp);
        if (p == 3) return 1'b1;
        if (p == 1) return m;
        return m && (!sp || s);
    endfunction

    function automatic void model(output int k, output int op, output int c,
                                  output logic [63:0] a);
        int f12 = int'(instr[31:20]);
        int e   = (int'(bexp) > 12) ? 12 : int'(bexp);
        bit match = instr[6:0] == 7'h0F && instr[14:12] == 3'd2 &&
                    instr[11:7] == 5'd0 && f12 < 3;
        bit en;
        a = rs1 & ~((64'd1 << e) - 64'd1);
        k = 0; op = 3; c = 0;
        if (match) begin
            op = f12;
            if (f12 == 0) en = allowed(int'(priv), m_inv[0], s_inv[0], s_pres);
            else          en = allowed(int'(priv), m_cf, s_cf, s_pres);
            if (f12 == 0 && !allowed(int'(priv), m_inv[1], s_inv[1], s_pres)) op = 2;
            if (!en)            begin k = 2; c = 2; end
            else if (xf)        begin k = 3; c = xp ? 15 : 7; end
            else if (rf && wf)  begin k = 3; c = wp ? 15 : 7; end
            else                k = 1;
        end
    endfunction

    task automatic compare(input string tag);
        n_tests++;
        if (o_valid !== e_valid || int'(o_kind) != e_kind || int'(o_op) != e_op ||
            int'(o_cause) != e_cause || o_addr !== e_addr) begin
            n_fail++;
            $display("FAIL %s: got v=%0b k=%0d op=%0d c=%0d a=%h, expected v=%0b k=%0d op=%0d c=%0d a=%h",
                     tag, o_valid, o_kind, o_op, o_cause, o_addr,
                     e_valid, e_kind, e_op, e_cause, e_addr);
        end
    endtask

    task automatic step(input string tag);
        int k, op, c;
        logic [63:0] a;
        model(k, op, c, a);
        @(negedge clk);
        e_valid = req_valid;
        if (req_valid) begin
            e_kind = k; e_op = op; e_cause = c; e_addr = a;
        end
        compare(tag);
    endtask

    task automatic dflt();
        req_valid = 1'b1; instr = mk(1); priv = 2'b11;
        m_cf = 1'b1; m_inv = 2'b11; s_cf = 1'b1; s_inv = 2'b11; s_pres = 1'b1;
        rs1 = 64'h0000_1234_5678_9ABF; bexp = 4'd6;
        xf = 1'b0; xp = 1'b0; rf = 1'b0; wf = 1'b0; wp = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        dflt();
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R10 reset state");

        // R1: frame and selector checks
        dflt(); instr = mk(1, 2, 0, 7'h33);  step("R1 wrong opcode");
        dflt(); instr = mk(1, 3);            step("R1 wrong funct3");
        dflt(); instr = mk(1, 2, 4);         step("R1 nonzero rd");
        dflt(); instr = mk(4);               step("R1 selector 4");
        dflt(); instr = mk(12'hFFF);         step("R1 selector all ones");

        // R2: machine mode with every config bit off
        dflt(); m_cf = 0; m_inv = 0; s_cf = 0; s_inv = 0;
        instr = mk(0); step("R2 machine invalidate");
        instr = mk(1); step("R2 machine clean");
        instr = mk(2); step("R2 machine flush");

        // R3: privilege rule
        dflt(); priv = 2'b01; m_cf = 0; instr = mk(1); step("R3 sup clean disabled");
        dflt(); priv = 2'b01; s_cf = 0; instr = mk(2); step("R3 sup flush ignores s bit");
        dflt(); priv = 2'b00; s_cf = 0;                step("R3 user s bit clear");
        dflt(); priv = 2'b00; s_cf = 0; s_pres = 0;    step("R3 user no sup mode");
        dflt(); priv = 2'b00; m_cf = 0; s_pres = 0;    step("R3 user m bit clear");
        dflt(); priv = 2'b10; s_cf = 0;                step("R3 reserved as user");

        // R4: enable bit selection
        dflt(); priv = 2'b01; m_inv = 2'b00; instr = mk(0); step("R4 inval disabled");
        dflt(); priv = 2'b01; m_cf = 0; m_inv = 2'b11; instr = mk(1);
        xf = 1; step("R4 clean disabled beats fault");
        dflt(); priv = 2'b01; m_cf = 0; m_inv = 2'b01; instr = mk(0);
        step("R4 inval uses own bit");

        // R5: demotion
        dflt(); priv = 2'b01; instr = mk(0);                 step("R5 sup true invalidate");
        dflt(); priv = 2'b00; s_inv = 2'b01; instr = mk(0);  step("R5 user demoted");
        dflt(); priv = 2'b00; s_inv = 2'b01; s_pres = 0; instr = mk(0);
        step("R5 user no sup mode keeps invalidate");

        // R6: alignment
        dflt(); rs1 = '1; bexp = 0;  step("R6 exponent 0");
        dflt(); rs1 = '1; bexp = 6;  step("R6 exponent 6");
        dflt(); rs1 = '1; bexp = 12; step("R6 exponent 12");
        dflt(); rs1 = '1; bexp = 15; step("R6 exponent clamped");

        // R7: translation failure
        dflt(); xf = 1; xp = 1;          step("R7 page fault");
        dflt(); xf = 1; xp = 0; wp = 1;  step("R7 access fault");

        // R8: either permission suffices
        dflt(); rf = 1; step("R8 write only");
        dflt(); wf = 1; wp = 1; step("R8 read only");

        // R9: both denied
        dflt(); rf = 1; wf = 1; wp = 1; step("R9 write page");
        dflt(); rf = 1; wf = 1; wp = 0; step("R9 write access");

        // R10: hold on idle, back-to-back
        dflt(); rf = 1; wf = 1; wp = 1; step("R10 load");
        dflt(); req_valid = 0; instr = mk(4); rs1 = '0; step("R10 idle hold");
        step("R10 idle again");
        dflt(); step("R10 back to back a");
        dflt(); instr = mk(0); priv = 2'b00; m_inv = 0; step("R10 back to back b");

        for (int i = 0; i < 400; i++) begin
            req_valid = ($urandom % 5) != 0;
            instr  = (($urandom % 8) == 0) ? 32'($urandom) : mk(int'($urandom % 5));
            priv   = 2'($urandom);
            m_cf   = 1'($urandom); s_cf = 1'($urandom); s_pres = 1'($urandom);
            m_inv  = 2'($urandom); s_inv = 2'($urandom);
            rs1    = {32'($urandom), 32'($urandom)};
            bexp   = 4'($urandom);
            xf = 1'($urandom % 4 == 0); xp = 1'($urandom);
            rf = 1'($urandom); wf = 1'($urandom); wp = 1'($urandom);
            step("R3/R8 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule